// File: doc/BRIEF.md
# Subband Buffer Sequencer

This block sits behind a one-dimensional wavelet filter pair and holds one whole region of its results. Each accepted input beat carries one low-pass coefficient and one high-pass coefficient. The two coefficients go into two separate storage banks at the same address. Addresses come from a fill counter that moves only on accepted beats. When the last location has been written, the block turns itself around and streams both banks back out. This read-out feeds the next transform pass.

The read-out walks a ROWS by COLS grid with a row index and a column index. In row order the column index is the inner loop. In column order the row index is the inner loop, which gives a transposed scan. Either way, the same stored region can feed a horizontal pass or a vertical pass. The order is taken from the mode input on the beat that completes the fill. A clock enable gates every advance, so the block can run at a divided sample rate. After the final word has been read, a one-cycle done pulse marks the end of the scan and the block is ready to fill again from address zero.

Top module: `subbuf_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `rd_wr`, `out_vld` and `done` are all 0.
- R2: While `rd_wr` is 0, a beat is accepted only when `ce` and `in_vld` are both 1. The k-th accepted beat (counting from 0) stores `lp_in` and `hp_in` at address k.
- R3: `rd_wr` becomes 1 on the clock edge that accepts beat ROWS*COLS-1. While `rd_wr` is 1, `in_vld` and the data inputs have no effect on the stored contents.
- R4: With row order selected (`col_mode` = 0), the n-th word read out comes from address n.
- R5: With column order selected (`col_mode` = 1), the n-th word read out comes from address (n mod ROWS)*COLS + (n div ROWS).
- R6: The scan order is sampled from `col_mode` on the edge that accepts the final fill beat. Changes to `col_mode` during the read-out have no effect.
- R7: During read-out, each edge with `ce` = 1 issues one read. The data and `out_vld` = 1 appear after that same edge, and `out_vld` is high for exactly one clock per read. An edge with `ce` = 0 issues no read, and `out_vld` is 0 after it.
- R8: `lp_out` always comes from the low-pass bank and `hp_out` from the high-pass bank, for the same address.
- R9: On the edge that issues the last read, `done` goes to 1 for one clock, together with the last data word. `rd_wr` returns to 0 on that same edge, and the next fill starts again at address 0.
- R10: An edge with `ce` = 0 changes no counter and no stored word, whatever `in_vld` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; every advance needs it |
| in_vld | input | 1 | Input beat valid during fill |
| lp_in | input | DW | Low-pass coefficient |
| hp_in | input | DW | High-pass coefficient |
| col_mode | input | 1 | Scan order: 0 row order, 1 column order |
| lp_out | output | DW | Low-pass word read out |
| hp_out | output | DW | High-pass word read out |
| out_vld | output | 1 | Read data valid |
| rd_wr | output | 1 | 0 while filling, 1 while reading |
| done | output | 1 | One-clock pulse with the final read word |

## Verification
The turn-around is due at the edge that accepts the final fill beat, so `rd_wr` must read 1 just after that edge. Every read word is due one edge after its issuing `ce` edge, and `done` is due at the edge that issues the final read. The bench drives its inputs just after a falling edge and samples the outputs at the next falling edge. At that point it advances its own model by exactly one edge, so each output is compared against the value due after the single rising edge in between. Stored data are checked by comparing every read word against the model's copy of the accepted beats, at the address the selected scan order gives.

// File: rtl/subbuf_pkg.sv
package subbuf_pkg;

  // Phase of the sequencer; the encoding is the value seen on rd_wr
  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;

  // Bank index for the two subbands
  localparam int BANK_LO = 0;
  localparam int BANK_HI = 1;
  localparam int N_BANKS = 2;

endpackage

// File: rtl/subbuf_cnt.sv
module subbuf_cnt #(
  parameter  int MAX = 255,
  localparam int W   = (MAX > 0) ? $clog2(MAX + 1) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         at_max
);

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  assign at_max = (q_q == W'(MAX));
  assign q      = q_q;

  always_comb begin
    q_d = q_q;
    if (inc) begin
      if (at_max) q_d = '0;
      else        q_d = q_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && at_max) |=> (q_q == '0));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(q_q));

endmodule

// File: rtl/subbuf_scan.sv
module subbuf_scan #(
  parameter  int ROWS = 16,
  parameter  int COLS = 32,
  localparam int AW   = $clog2(ROWS * COLS),
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          col_mode,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          row_max;
  logic          col_max;
  logic          row_inc;
  logic          col_inc;

  // The inner index moves on every step; the outer one moves when the inner wraps
  always_comb begin
    if (col_mode) begin
      row_inc = step;
      col_inc = step && row_max;
    end else begin
      col_inc = step;
      row_inc = step && col_max;
    end
  end

  subbuf_cnt #(.MAX(ROWS - 1)) i_row_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (row_inc),
    .q      (row_q),
    .at_max (row_max)
  );

  subbuf_cnt #(.MAX(COLS - 1)) i_col_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (col_inc),
    .q      (col_q),
    .at_max (col_max)
  );

  assign last = row_max && col_max;

  generate
    if ((1 << CW) == COLS) begin : g_pow2
      assign addr = {row_q, col_q};
    end else begin : g_mul
      assign addr = AW'(row_q) * AW'(COLS) + AW'(col_q);
    end
  endgenerate

  // R4
  row_inner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !col_mode && !col_max) |=> ((col_q == $past(col_q) + CW'(1)) && $stable(row_q)));

  // R5
  col_inner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && col_mode && !row_max) |=> ((row_q == $past(row_q) + RW'(1)) && $stable(col_q)));

endmodule

// File: rtl/subbuf_bank.sv
module subbuf_bank #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R3
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));

endmodule

// File: rtl/subbuf_seq.sv
module subbuf_seq
  import subbuf_pkg::*;
#(
  parameter  int DW    = 16,
  parameter  int ROWS  = 16,
  parameter  int COLS  = 32,
  localparam int DEPTH = ROWS * COLS,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          in_vld,
  input  logic [DW-1:0] lp_in,
  input  logic [DW-1:0] hp_in,
  input  logic          col_mode,
  output logic [DW-1:0] lp_out,
  output logic [DW-1:0] hp_out,
  output logic          out_vld,
  output logic          rd_wr,
  output logic          done
);

  phase_e        phase_q, phase_d;
  logic          mode_q, mode_d;
  logic          done_q, done_d;
  logic          vld_q, vld_d;

  logic          wr_fire;
  logic          rd_fire;
  logic [AW-1:0] wr_addr;
  logic          wr_last;
  logic [AW-1:0] rd_addr;
  logic          rd_last;

  logic [DW-1:0] bank_wdata [N_BANKS];
  logic [DW-1:0] bank_rdata [N_BANKS];

  assign wr_fire = ce && in_vld && (phase_q == PH_FILL);
  assign rd_fire = ce && (phase_q == PH_DRAIN);

  // Fill address counter
  subbuf_cnt #(.MAX(DEPTH - 1)) i_wr_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (wr_fire),
    .q      (wr_addr),
    .at_max (wr_last)
  );

  // Row/column read scanner
  subbuf_scan #(.ROWS(ROWS), .COLS(COLS)) i_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (rd_fire),
    .col_mode (mode_q),
    .addr     (rd_addr),
    .last     (rd_last)
  );

  assign bank_wdata[BANK_LO] = lp_in;
  assign bank_wdata[BANK_HI] = hp_in;

  generate
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      subbuf_bank #(.DW(DW), .DEPTH(DEPTH)) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire),
        .waddr (wr_addr),
        .wdata (bank_wdata[b]),
        .re    (rd_fire),
        .raddr (rd_addr),
        .rdata (bank_rdata[b])
      );
    end
  endgenerate

  always_comb begin
    phase_d = phase_q;
    mode_d  = mode_q;
    done_d  = rd_fire && rd_last;
    vld_d   = rd_fire;
    if (wr_fire && wr_last) begin
      phase_d = PH_DRAIN;
      mode_d  = col_mode;
    end else if (rd_fire && rd_last) begin
      phase_d = PH_FILL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
      vld_q   <= vld_d;
    end
  end

  assign lp_out  = bank_rdata[BANK_LO];
  assign hp_out  = bank_rdata[BANK_HI];
  assign out_vld = vld_q;
  assign rd_wr   = (phase_q == PH_DRAIN);
  assign done    = done_q;

  // R3
  turn_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_DRAIN) |-> (wr_addr == '0));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_DRAIN) && ($past(phase_q) == PH_DRAIN)) |-> $stable(mode_q));

  // R7
  vld_from_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($past(phase_q) == PH_DRAIN));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  done_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (out_vld && (phase_q == PH_FILL) && (wr_addr == '0)));

endmodule

// File: tb/test_subbuf_seq.sv
module test_subbuf_seq;

  localparam int DW    = 16;
  localparam int ROWS  = 16;
  localparam int COLS  = 32;
  localparam int DEPTH = ROWS * COLS;

  logic          clk;
  logic          rst_n;
  logic          ce;
  logic          in_vld;
  logic [DW-1:0] lp_in;
  logic [DW-1:0] hp_in;
  logic          col_mode;
  logic [DW-1:0] lp_out;
  logic [DW-1:0] hp_out;
  logic          out_vld;
  logic          rd_wr;
  logic          done;

  subbuf_seq #(.DW(DW), .ROWS(ROWS), .COLS(COLS)) i_subbuf_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (ce),
    .in_vld   (in_vld),
    .lp_in    (lp_in),
    .hp_in    (hp_in),
    .col_mode (col_mode),
    .lp_out   (lp_out),
    .hp_out   (hp_out),
    .out_vld  (out_vld),
    .rd_wr    (rd_wr),
    .done     (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  // Bench model state
  logic [DW-1:0] ref_lp [DEPTH];
  logic [DW-1:0] ref_hp [DEPTH];
  int            m_cnt  = 0;
  int            m_idx  = 0;
  bit            m_rd   = 1'b0;
  bit            m_mode = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_addr(input bit cmode, input int n);
    if (cmode) return (n % ROWS) * COLS + (n / ROWS);
    return n;
  endfunction

  // Drive one set of inputs, let one rising edge pass, then advance the model and compare
  task automatic cyc(input bit d_ce, input bit d_vld, input bit d_mode);
    logic [DW-1:0] d_lp;
    logic [DW-1:0] d_hp;
    logic [DW-1:0] e_lp;
    logic [DW-1:0] e_hp;
    bit            e_vld;
    bit            e_done;
    int            a;
    d_lp     = DW'($urandom);
    d_hp     = DW'($urandom);
    ce       = d_ce;
    in_vld   = d_vld;
    lp_in    = d_lp;
    hp_in    = d_hp;
    col_mode = d_mode;
    @(negedge clk);
    e_vld  = 1'b0;
    e_done = 1'b0;
    e_lp   = '0;
    e_hp   = '0;
    if (!m_rd) begin
      // R2, R10: only ce && in_vld stores, at consecutive addresses
      if (d_ce && d_vld) begin
        ref_lp[m_cnt] = d_lp;
        ref_hp[m_cnt] = d_hp;
        if (m_cnt == DEPTH - 1) begin
          m_rd   = 1'b1;
          m_mode = d_mode;  // R6: order sampled on the final fill beat
          m_cnt  = 0;
        end else begin
          m_cnt++;
        end
      end
    end else if (d_ce) begin
      a      = exp_addr(m_mode, m_idx);
      e_lp   = ref_lp[a];
      e_hp   = ref_hp[a];
      e_vld  = 1'b1;
      if (m_idx == DEPTH - 1) begin
        e_done = 1'b1;
        m_rd   = 1'b0;
        m_idx  = 0;
      end else begin
        m_idx++;
      end
    end
    chk(rd_wr == m_rd, "R3 rd_wr", int'(rd_wr), int'(m_rd));
    chk(out_vld == e_vld, "R7 out_vld", int'(out_vld), int'(e_vld));
    chk(done == e_done, "R9 done", int'(done), int'(e_done));
    if (e_vld) begin
      if (m_mode) chk(lp_out == e_lp, "R5 lp_out column order", int'(lp_out), int'(e_lp));
      else        chk(lp_out == e_lp, "R4 lp_out row order", int'(lp_out), int'(e_lp));
      chk(hp_out == e_hp, "R8 hp_out", int'(hp_out), int'(e_hp));
    end
  endtask

  // One fill and one full read-out
  task automatic run_round(input bit dense, input bit want_mode, input bit noisy);
    bit c;
    bit v;
    bit m;
    while (!m_rd) begin
      c = dense ? 1'b1 : (($urandom % 4) != 0);
      v = dense ? 1'b1 : (($urandom % 10) < 7);
      m = noisy ? 1'($urandom) : want_mode;
      if (c && v && (m_cnt == DEPTH - 1)) m = want_mode;
      cyc(c, v, m);
    end
    // R3, R6: in_vld and col_mode keep moving during read-out
    while (m_rd) begin
      c = dense ? 1'b1 : (($urandom % 4) != 0);
      v = 1'($urandom);
      m = noisy ? 1'($urandom) : ~want_mode;
      cyc(c, v, m);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n    = 1'b0;
    ce       = 1'b0;
    in_vld   = 1'b0;
    lp_in    = '0;
    hp_in    = '0;
    col_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    chk(rd_wr == 1'b0, "R1 rd_wr in reset", int'(rd_wr), 0);
    chk(out_vld == 1'b0, "R1 out_vld in reset", int'(out_vld), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_wr == 1'b0, "R1 rd_wr after reset", int'(rd_wr), 0);
    chk(out_vld == 1'b0, "R1 out_vld after reset", int'(out_vld), 0);
    // R10: valid beats without ce are dropped (caught by later readback)
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 1'b1);
    run_round(1'b1, 1'b1, 1'b0);  // back-to-back fill, column order
    run_round(1'b0, 1'b0, 1'b1);  // gapped, row order, noisy mode pin
    run_round(1'b0, 1'b1, 1'b1);  // gapped, column order
    run_round(1'b1, 1'b0, 1'b0);  // dense row order, mode flipped during read
    repeat (3) cyc(1'b1, 1'b0, 1'b0);
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule